// File: doc/BRIEF.md
# Vectored Interrupt Port Controller

This block is the controller side of a vectored interrupt link between a bank of peripheral request lines and a processor. Each of the sixteen active-high request lines is brought onto the bus clock by a two-flop synchronizer. A registered priority stage then chooses one pending line, where the smallest index wins. While a line is pending, the block drives an active-low interrupt output and a 32-bit vector address. The address comes from a per-source vector register. When nothing is pending, it comes from a programmable fallback vector.

The processor answers the interrupt by raising an acknowledge input. The controller reacts by raising an address-valid output. From that point the vector address is frozen, even if a more urgent request arrives. Once the processor drops acknowledge, the controller holds address-valid and the interrupt output for one more cycle. It then releases both of them together.

The source that was just serviced stays masked until its synchronized request has been seen low. A level that stays high therefore cannot cause a second acknowledge. Vector registers and the fallback vector are loaded through a one-cycle write port.

Top module: `vec_irq_port`

## Requirements
- R1: While `rst` is high, and after it, `irq_n` is 1, `vect_valid` is 0 and `vect_addr` is 0 until something else is loaded.
- R2: A request raised on `irq_req[i]` first drives `irq_n` low after the fourth rising clock edge that samples it high: two synchronizer edges, one priority edge and one handshake edge.
- R3: While the interrupt is pending, `vect_addr` is the vector register of the pending source with the lowest index. If a lower index becomes pending before acknowledge, the address follows it.
- R4: When `cpu_ack` is sampled high while the interrupt is pending, `vect_valid` is high after the very next rising edge. This holds however many cycles the acknowledge was delayed.
- R5: While `vect_valid` is high, `vect_addr` does not change, even when a higher-priority request is raised.
- R6: The edge that samples `cpu_ack` low during the valid phase leaves `vect_valid` high and `irq_n` low for one more cycle. The following edge drops `vect_valid` to 0 and raises `irq_n` to 1 together.
- R7: A serviced source is masked from acknowledge until its synchronized request is seen low. A held request does not re-raise `irq_n`, and a fresh rising request is served again.
- R8: `cpu_ack` has no effect while no interrupt is pending: `vect_valid` stays 0 and `irq_n` stays 1.
- R9: A write with `cfg_we` high stores `cfg_data` as the vector of source `cfg_idx`. A write with `cfg_dflt_we` high stores the fallback vector, which `vect_addr` shows when nothing is pending.
- R10: A lower-priority request still pending at release is signalled as a new interrupt, with its own vector, right after the one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC (16) | Asynchronous active-high request lines, bit 0 most urgent |
| cfg_we | input | 1 | Write strobe for a per-source vector |
| cfg_dflt_we | input | 1 | Write strobe for the fallback vector |
| cfg_idx | input | $clog2(NUM_SRC) (4) | Source selected by a vector write |
| cfg_data | input | ADDR_W (32) | Vector value to write |
| cpu_ack | input | 1 | Processor acknowledge, high while servicing |
| irq_n | output | 1 | Active-low interrupt to the processor |
| vect_valid | output | 1 | High while the vector address is stable for sampling |
| vect_addr | output | ADDR_W (32) | Vector address |

## Verification
Two things can land on the same edge here. The first is the freezing of the vector when acknowledge is taken. The second is the arrival, through the synchronizer and priority stages, of a more urgent request. The bench raises a lower-index line while the handshake for another line is in its valid phase. It then requires the address to stay unchanged until release, and after that it requires the new line's vector. The release itself is judged cycle by cycle: address-valid and the interrupt output must change on the same edge, one cycle after acknowledge is seen low.

// File: rtl/vip_pkg.sv
package vip_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_PENDING = 2'd1,
    HS_VALID   = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_e;

  // Index of the lowest set bit; 0 when none set (caller checks emptiness).
  function automatic logic [5:0] lowest_set(input logic [63:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/vip_sync.sv
module vip_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;

endmodule

// File: rtl/vip_prio.sv
module vip_prio #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_s,
  input  logic          mask_set,
  input  logic [IW-1:0] mask_idx,
  output logic          win_valid,
  output logic [IW-1:0] win_idx
);

  import vip_pkg::*;

  logic [N-1:0]  mask_q;
  logic [N-1:0]  eligible;
  logic [63:0]   elig_wide;
  logic          win_valid_q;
  logic [IW-1:0] win_idx_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst)
          mask_q[g] <= 1'b0;
        else if (mask_set && (mask_idx == IW'(g)))
          mask_q[g] <= 1'b1;
        else if (!req_s[g])
          mask_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign eligible  = req_s & ~mask_q;
  assign elig_wide = 64'(eligible);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid_q <= 1'b0;
      win_idx_q   <= '0;
    end else begin
      win_valid_q <= |eligible;
      win_idx_q   <= IW'(lowest_set(elig_wide));
    end
  end

  assign win_valid = win_valid_q;
  assign win_idx   = win_idx_q;

endmodule

// File: rtl/vip_hs_fsm.sv
module vip_hs_fsm (
  input  logic                clk,
  input  logic                rst,
  input  logic                win_valid,
  input  logic                cpu_ack,
  output vip_pkg::hs_state_e  state,
  output logic                addr_load,
  output logic                enter_valid,
  output logic                release_done,
  output logic                irq_n,
  output logic                vect_valid
);

  import vip_pkg::*;

  hs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE:    if (win_valid) st_d = HS_PENDING;
      HS_PENDING: begin
        if (cpu_ack)         st_d = HS_VALID;
        else if (!win_valid) st_d = HS_IDLE;
      end
      HS_VALID:   if (!cpu_ack) st_d = HS_RELEASE;
      HS_RELEASE: st_d = HS_IDLE;
      default:    st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= HS_IDLE;
    else     st_q <= st_d;
  end

  assign state        = st_q;
  assign enter_valid  = (st_q == HS_PENDING) && cpu_ack;
  assign release_done = (st_q == HS_RELEASE);
  assign addr_load    = (st_q == HS_IDLE) || ((st_q == HS_PENDING) && !cpu_ack);
  assign irq_n        = (st_q == HS_IDLE);
  assign vect_valid   = (st_q == HS_VALID) || (st_q == HS_RELEASE);

endmodule

// File: rtl/vip_vec_table.sv
module vip_vec_table #(
  parameter int N  = 16,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_dflt,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] dflt
);

  logic [AW-1:0] tab_q [N];
  logic [AW-1:0] dflt_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst)
          tab_q[g] <= '0;
        else if (wr_en && (wr_idx == IW'(g)))
          tab_q[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          dflt_q <= '0;
    else if (wr_dflt) dflt_q <= wr_data;
  end

  assign rd_data = tab_q[rd_idx];
  assign dflt    = dflt_q;

endmodule

// File: rtl/vec_irq_port.sv
module vec_irq_port #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               cfg_we,
  input  logic               cfg_dflt_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ADDR_W-1:0]  cfg_data,
  input  logic               cpu_ack,
  output logic               irq_n,
  output logic               vect_valid,
  output logic [ADDR_W-1:0]  vect_addr
);

  import vip_pkg::*;

  logic [NUM_SRC-1:0] req_s;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  hs_state_e          hs_state;
  logic               addr_load;
  logic               enter_valid;
  logic               release_done;
  logic [ADDR_W-1:0]  tab_rd;
  logic [ADDR_W-1:0]  tab_dflt;
  logic [ADDR_W-1:0]  addr_gen;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDX_W-1:0]   shown_idx_q;
  logic               shown_vld_q;
  logic               mask_set;

  vip_sync #(.W(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_req),
    .d_sync  (req_s)
  );

  vip_prio #(.N(NUM_SRC)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .req_s     (req_s),
    .mask_set  (mask_set),
    .mask_idx  (shown_idx_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  vip_hs_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .win_valid    (win_valid),
    .cpu_ack      (cpu_ack),
    .state        (hs_state),
    .addr_load    (addr_load),
    .enter_valid  (enter_valid),
    .release_done (release_done),
    .irq_n        (irq_n),
    .vect_valid   (vect_valid)
  );

  vip_vec_table #(.N(NUM_SRC), .AW(ADDR_W)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_dflt (cfg_dflt_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .rd_idx  (win_idx),
    .rd_data (tab_rd),
    .dflt    (tab_dflt)
  );

  assign addr_gen = win_valid ? tab_rd : tab_dflt;
  // Mask the source whose vector the processor is taking.
  assign mask_set = enter_valid && shown_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      shown_idx_q <= '0;
      shown_vld_q <= 1'b0;
    end else if (addr_load) begin
      addr_q      <= addr_gen;
      shown_idx_q <= win_idx;
      shown_vld_q <= win_valid;
    end
  end

  assign vect_addr = addr_q;

endmodule

// File: rtl/vip_chk.sv
module vip_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ack,
  input logic              irq_n,
  input logic              vect_valid,
  input logic [ADDR_W-1:0] vect_addr,
  input logic              enter_valid,
  input logic              release_done
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (irq_n && !vect_valid));

  // R4
  valid_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vect_valid) |-> $past(cpu_ack));

  // R4
  enter_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    enter_valid |=> vect_valid);

  // R5
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (vect_valid && $past(vect_valid)) |-> $stable(vect_addr));

  // R6
  joint_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vect_valid) |-> ($rose(irq_n) && !$past(cpu_ack)));

  // R6
  release_done_chk: assert property (@(posedge clk) disable iff (rst)
    release_done |=> (irq_n && !vect_valid));

  // R6
  valid_implies_irq_chk: assert property (@(posedge clk) disable iff (rst)
    vect_valid |-> !irq_n);

endmodule

bind vec_irq_port vip_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_ack      (cpu_ack),
  .irq_n        (irq_n),
  .vect_valid   (vect_valid),
  .vect_addr    (vect_addr),
  .enter_valid  (enter_valid),
  .release_done (release_done)
);

// File: tb/tb_vec_irq_port.sv
module tb_vec_irq_port;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int AW = 32;
  localparam logic [AW-1:0] DFLT = 32'hDEAD_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_req = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_dflt_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          cpu_ack = 1'b0;
  logic          irq_n;
  logic          vect_valid;
  logic [AW-1:0] vect_addr;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_port dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_dflt_we(cfg_dflt_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cpu_ack(cpu_ack), .irq_n(irq_n), .vect_valid(vect_valid),
    .vect_addr(vect_addr)
  );

  function automatic logic [AW-1:0] vec_of(input int i);
    return 32'h4000_0100 + 32'(i) * 32'h18;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: on each rise of address-valid, compare with scoreboard (R5).
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst && vect_valid && !prev_v) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected valid", vect_addr, '0);
      else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(vect_addr == e, "R5 sampled vector", vect_addr, e);
      end
    end
    prev_v = vect_valid;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Handshake driver: called with irq_n low. Optional intruder raised in VALID.
  task automatic serve(input int idx, input int delay, input int intruder);
    logic [AW-1:0] e;
    e = vec_of(idx);
    cyc(delay);
    chk(!irq_n && vect_addr == e, "R3 pending vector", vect_addr, e);
    exp_q.push_back(e);
    cpu_ack = 1'b1;
    cyc(1);
    chk(vect_valid == 1'b1, "R4 valid one cycle after ack", 32'(vect_valid), 32'd1);
    if (intruder >= 0) irq_req[intruder] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      cyc(1);
      chk(vect_addr == e, "R5 address frozen", vect_addr, e);
    end
    cpu_ack = 1'b0;
    cyc(1);
    chk(vect_valid && !irq_n, "R6 held one cycle", {30'd0, vect_valid, irq_n}, 32'd2);
    cyc(1);
    chk(!vect_valid && irq_n, "R6 joint drop", {30'd0, vect_valid, irq_n}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", '0, '0);
      finish_run();
    end
  end

  initial begin
    cyc(1);
    chk(irq_n && !vect_valid && vect_addr == 0, "R1 in reset",
        {vect_addr[29:0], vect_valid, irq_n}, 32'd1);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk(irq_n && !vect_valid && vect_addr == 0, "R1 after reset",
        {vect_addr[29:0], vect_valid, irq_n}, 32'd1);

    // R9: program vectors and fallback
    for (int i = 0; i < NS; i++) begin
      cfg_we = 1'b1; cfg_idx = 4'(i); cfg_data = vec_of(i);
      cyc(1);
    end
    cfg_we = 1'b0; cfg_dflt_we = 1'b1; cfg_data = DFLT;
    cyc(1);
    cfg_dflt_we = 1'b0;
    cyc(2);
    chk(vect_addr == DFLT, "R9 fallback vector when idle", vect_addr, DFLT);

    // R8: ack with nothing pending
    cpu_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk(!vect_valid && irq_n, "R8 stray ack ignored", {30'd0, vect_valid, irq_n}, 32'd1);
    end
    cpu_ack = 1'b0;
    cyc(1);

    // R2: latency of four edges
    irq_req[5] = 1'b1;
    cyc(3);
    chk(irq_n == 1'b1, "R2 not yet after three edges", 32'(irq_n), 32'd1);
    cyc(1);
    chk(irq_n == 1'b0, "R2 asserted after four edges", 32'(irq_n), 32'd0);
    chk(vect_addr == vec_of(5), "R9 programmed vector shown", vect_addr, vec_of(5));

    // R5: higher-priority source 1 raised during VALID
    serve(5, 0, 1);
    // R10: lower index still pending -> new interrupt after one idle cycle
    cyc(1);
    chk(!irq_n && vect_addr == vec_of(1), "R10 next source signalled", vect_addr, vec_of(1));
    // R4: late acknowledge
    serve(1, 6, -1);

    // R7: both held high but masked
    for (int k = 0; k < 8; k++) begin
      cyc(1);
      chk(irq_n == 1'b1, "R7 held level masked", 32'(irq_n), 32'd1);
    end
    irq_req[5] = 1'b0; irq_req[1] = 1'b0;
    cyc(4);
    irq_req[5] = 1'b1;
    cyc(4);
    chk(!irq_n && vect_addr == vec_of(5), "R7 fresh request served again", vect_addr, vec_of(5));
    serve(5, 1, -1);
    irq_req[5] = 1'b0;
    cyc(4);

    // R3: two at once, lowest index wins; then pending follows a lower one
    irq_req[9] = 1'b1; irq_req[3] = 1'b1;
    cyc(4);
    chk(vect_addr == vec_of(3), "R3 lowest index wins", vect_addr, vec_of(3));
    irq_req[0] = 1'b1;
    cyc(4);
    chk(!irq_n && vect_addr == vec_of(0), "R3 pending follows lower index", vect_addr, vec_of(0));
    serve(0, 0, -1);
    cyc(1);
    serve(3, 0, -1);
    cyc(1);
    serve(9, 0, -1);
    irq_req = '0;
    cyc(6);
    chk(irq_n && vect_addr == DFLT, "R9 fallback after drain", vect_addr, DFLT);
    chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule